// File: doc/BRIEF.md
# Priority Interrupt Controller with Wake Filtering

The controller picks one interrupt at a time from a set of maskable sources and one top-level source that cannot be masked. Each maskable source has a two-bit software level. The highest level wins. When levels are equal, a fixed hardware order decides: the top-level source first, then maskable source 0, then source 1, and so on. The winner is shown as a one-hot grant and an encoded vector. It stays on the outputs until the core acknowledges it. On acknowledge, the controller saves the running level on a small internal stack and takes the granted level as the new running level. A return strobe restores the saved level.

One static input selects the servicing style. In concurrent mode, nothing is granted while a service is in progress. In nested mode, a request preempts only when its level is strictly above the running level.

The controller also produces a wake signal for two low-power states. In the light sleep state, any enabled request wakes the core. In the deep sleep state, only sources flagged as deep-wake capable wake it, and the first grant after that state comes from those sources only. If a source that is not capable would otherwise have won, it is deferred. It is then granted as soon as that first service returns, ahead of any other request.

Top module: `ic_prio_ctrl`

## Requirements
- R1: After reset, `irq_vld`, `cpu_lvl`, `stk_depth`, `stk_err` and `wake` are all zero.
- R2: The winner is the eligible request with the highest level. Ties go to the lowest vector number. The vector number is 0 for the top-level source and k+1 for maskable source k. The top-level source has fixed level 3 and cannot be disabled. `irq_grant` has exactly bit `irq_vec` set while `irq_vld` is high.
- R3: A maskable source whose level field `irq_lvl[2k+1:2k]` is 00 is never granted and never causes a wake.
- R4: Once `irq_vld` rises, the grant and vector hold until `ack`, even if the request is withdrawn.
- R5: On `ack`, `cpu_lvl` takes the granted level and the previous level is pushed, so `stk_depth` rises by one. On `rti`, the top level is popped into `cpu_lvl`. With an empty stack, `rti` sets `cpu_lvl` to 0. `ack` takes precedence over a simultaneous `rti`.
- R6: With `nested_en`=0, no new grant is latched while `stk_depth` is nonzero.
- R7: With `nested_en`=1, a request is granted only if its level is strictly greater than `cpu_lvl`.
- R8: An `ack` with a full stack sets the sticky flag `stk_err`. The level is still loaded, but the push is dropped and the depth stays at its maximum.
- R9: With `sleep_st`=01 (light sleep), `wake` is high whenever any enabled request is pending.
- R10: With `sleep_st`=10 (deep sleep), `wake` is high only for pending enabled requests whose `halt_cap` bit is set. The top-level source always counts as capable.
- R11: From any cycle spent in deep sleep until the next `ack`, only capable sources can be latched as the grant.
- R12: A non-capable request that beat the first post-sleep grant in unrestricted arbitration is granted next, ahead of all other requests, once the stack returns to its depth from before that grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nested_en | input | 1 | 1 selects nested servicing, 0 selects concurrent |
| sleep_st | input | 2 | 00 run, 01 light sleep, 10 deep sleep, 11 run |
| irq_req | input | N_SRC | Maskable request lines |
| tli_req | input | 1 | Top-level non-maskable request |
| irq_lvl | input | 2*N_SRC | Software level per source; field k is bits 2k+1:2k |
| halt_cap | input | N_SRC | Deep-wake capable flag per maskable source |
| ack | input | 1 | Core acknowledges the presented vector |
| rti | input | 1 | Return-from-interrupt strobe |
| irq_vld | output | 1 | A grant is being presented |
| irq_grant | output | N_SRC+1 | One-hot grant; bit 0 is the top-level source |
| irq_vec | output | clog2(N_SRC+1) | Encoded vector of the grant |
| cpu_lvl | output | 2 | Running software level |
| stk_depth | output | clog2(STK_DEPTH+1) | Saved levels on the stack |
| stk_err | output | 1 | Sticky stack overflow flag |
| wake | output | 1 | Wake request for the current sleep state |

## Verification
The bench targets four corner cases:

- **Equal levels.** Ties between equal levels are checked against the fixed order. A reversed tie-break would grant source 3 instead of source 1.
- **Equal-level preemption in nested mode.** A design that used a greater-or-equal comparison would let a level-1 request preempt a level-1 service.
- **Deep-sleep exit.** A higher-level request that is not capable is pending alongside a capable one, and the top-level source arrives during the first service. A design that skipped the restriction would grant the wrong source first. A design that forgot the deferral would grant the top-level source instead of the deferred request.
- **Stack overflow.** A reduced-depth stack is overflowed. A design that pushed anyway, or that cleared the flag later, would restore the wrong level or lose the error.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [1:0] {
    SLP_RUN  = 2'b00,
    SLP_WAIT = 2'b01,
    SLP_HALT = 2'b10,
    SLP_RSV  = 2'b11
  } slp_e;

  localparam logic [1:0] LVL_OFF = 2'b00;
  localparam logic [1:0] LVL_TOP = 2'b11;
endpackage

// File: rtl/ic_arb.sv
module ic_arb #(
  parameter int N  = 6,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]   cand,
  input  logic [2*N-1:0] lvl,
  output logic           any,
  output logic [IW-1:0]  idx,
  output logic [1:0]     lvl_o
);
  // Scan from the lowest rank upward; ">=" lets a lower index take ties.
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    lvl_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (!any || (lvl[2*i +: 2] >= lvl_o))) begin
        any   = 1'b1;
        idx   = IW'(i);
        lvl_o = lvl[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/ic_lvl_stack.sv
module ic_lvl_stack #(
  parameter int DEPTH = 4,
  parameter int LW    = 2,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] din,
  output logic [LW-1:0] top,
  output logic [DW-1:0] depth,
  output logic          ovf
);
  logic [LW-1:0] mem [DEPTH];
  logic [DW-1:0] depth_q, depth_d;
  logic          ovf_q, ovf_d;
  logic          full, empty;

  assign full  = (depth_q == DW'(DEPTH));
  assign empty = (depth_q == '0);

  always_comb begin
    depth_d = depth_q;
    ovf_d   = ovf_q;
    if (push) begin
      if (full) ovf_d = 1'b1;
      else      depth_d = depth_q + DW'(1);
    end else if (pop && !empty) begin
      depth_d = depth_q - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[depth_q[AW-1:0]] <= din;
  end

  assign top   = empty ? '0 : mem[AW'(depth_q - DW'(1))];
  assign depth = depth_q;
  assign ovf   = ovf_q;

  AST_STK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DW'(DEPTH)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R8
  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf_q && $stable(depth_q)); // R8
endmodule

// File: rtl/ic_prio_ctrl.sv
module ic_prio_ctrl
  import ic_pkg::*;
#(
  parameter int N_SRC     = 5,
  parameter int STK_DEPTH = 4,
  localparam int NA = N_SRC + 1,
  localparam int VW = $clog2(NA),
  localparam int DW = $clog2(STK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nested_en,
  input  logic [1:0]         sleep_st,
  input  logic [N_SRC-1:0]   irq_req,
  input  logic               tli_req,
  input  logic [2*N_SRC-1:0] irq_lvl,
  input  logic [N_SRC-1:0]   halt_cap,
  input  logic               ack,
  input  logic               rti,
  output logic               irq_vld,
  output logic [NA-1:0]      irq_grant,
  output logic [VW-1:0]      irq_vec,
  output logic [1:0]         cpu_lvl,
  output logic [DW-1:0]      stk_depth,
  output logic               stk_err,
  output logic               wake
);
  // Arbiter order: slot 0 is the top-level source, slot k+1 is source k.
  logic [NA-1:0]   en_x, cap_x, elig_x, cand_r;
  logic [2*NA-1:0] lvl_x;
  logic [1:0]      cur_q, cur_d, glvl_q, glvl_d, stk_top;
  logic            vld_q, vld_d, lock_q, lock_d;
  logic [VW-1:0]   gidx_q, gidx_d;
  logic            dfr_vld_q, dfr_vld_d, dfr_rdy_q, dfr_rdy_d;
  logic [VW-1:0]   dfr_idx_q, dfr_idx_d;
  logic [DW-1:0]   dfr_base_q, dfr_base_d, depth_w;
  logic            restrict_c, forced, ack_ok, rti_ok;
  logic            r_any, f_any;
  logic [VW-1:0]   r_idx, f_idx;
  logic [1:0]      r_lvl, f_lvl;
  logic            in_halt;

  assign in_halt = (sleep_st == SLP_HALT);

  assign en_x[0]     = tli_req;
  assign cap_x[0]    = 1'b1;
  assign lvl_x[1:0]  = LVL_TOP;

  genvar k;
  generate
    for (k = 0; k < N_SRC; k++) begin : g_src
      assign lvl_x[2*(k+1) +: 2] = irq_lvl[2*k +: 2];
      assign en_x[k+1]  = irq_req[k] && (irq_lvl[2*k +: 2] != LVL_OFF);
      assign cap_x[k+1] = halt_cap[k];
    end
    for (k = 0; k < NA; k++) begin : g_elig
      assign elig_x[k] = en_x[k] &&
        (nested_en ? (lvl_x[2*k +: 2] > cur_q) : (depth_w == '0));
    end
  endgenerate

  assign restrict_c = lock_q || in_halt;
  assign cand_r     = restrict_c ? (elig_x & cap_x) : elig_x;

  ic_arb #(.N(NA)) u_arb_r (.cand(cand_r), .lvl(lvl_x),
                            .any(r_any), .idx(r_idx), .lvl_o(r_lvl));
  ic_arb #(.N(NA)) u_arb_f (.cand(elig_x), .lvl(lvl_x),
                            .any(f_any), .idx(f_idx), .lvl_o(f_lvl));

  assign ack_ok = ack && vld_q;
  assign rti_ok = rti && !ack_ok;
  assign forced = dfr_rdy_q && en_x[dfr_idx_q];

  ic_lvl_stack #(.DEPTH(STK_DEPTH), .LW(2)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(ack_ok), .pop(rti_ok),
    .din(cur_q), .top(stk_top), .depth(depth_w), .ovf(stk_err));

  // Next-state logic
  always_comb begin
    vld_d      = vld_q;
    gidx_d     = gidx_q;
    glvl_d     = glvl_q;
    cur_d      = cur_q;
    dfr_vld_d  = dfr_vld_q;
    dfr_rdy_d  = dfr_rdy_q;
    dfr_idx_d  = dfr_idx_q;
    dfr_base_d = dfr_base_q;
    lock_d     = in_halt || (lock_q && !ack_ok);

    if (ack_ok) begin
      vld_d = 1'b0;
      cur_d = glvl_q;
    end else if (!vld_q && (forced || r_any)) begin
      vld_d  = 1'b1;
      gidx_d = forced ? dfr_idx_q : r_idx;
      glvl_d = forced ? lvl_x[{dfr_idx_q, 1'b0} +: 2] : r_lvl;
    end
    if (rti_ok) cur_d = stk_top;

    if (ack_ok && lock_q && f_any && (f_idx != gidx_q) && !cap_x[f_idx]) begin
      dfr_vld_d  = 1'b1;
      dfr_rdy_d  = 1'b0;
      dfr_idx_d  = f_idx;
      dfr_base_d = depth_w;
    end else if (ack_ok && dfr_rdy_q && (gidx_q == dfr_idx_q)) begin
      dfr_vld_d = 1'b0;
      dfr_rdy_d = 1'b0;
    end else if (rti_ok && dfr_vld_q && !dfr_rdy_q &&
                 (depth_w == dfr_base_q + DW'(1))) begin
      dfr_rdy_d = 1'b1;
    end else if (dfr_rdy_q && !en_x[dfr_idx_q]) begin
      dfr_vld_d = 1'b0;
      dfr_rdy_d = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      gidx_q     <= '0;
      glvl_q     <= '0;
      cur_q      <= '0;
      lock_q     <= 1'b0;
      dfr_vld_q  <= 1'b0;
      dfr_rdy_q  <= 1'b0;
      dfr_idx_q  <= '0;
      dfr_base_q <= '0;
    end else begin
      vld_q      <= vld_d;
      gidx_q     <= gidx_d;
      glvl_q     <= glvl_d;
      cur_q      <= cur_d;
      lock_q     <= lock_d;
      dfr_vld_q  <= dfr_vld_d;
      dfr_rdy_q  <= dfr_rdy_d;
      dfr_idx_q  <= dfr_idx_d;
      dfr_base_q <= dfr_base_d;
    end
  end

  always_comb begin
    irq_grant = '0;
    if (vld_q) irq_grant[gidx_q] = 1'b1;
  end

  always_comb begin
    unique case (sleep_st)
      SLP_WAIT: wake = |en_x;
      SLP_HALT: wake = |(en_x & cap_x);
      default:  wake = 1'b0;
    endcase
  end

  assign irq_vld   = vld_q;
  assign irq_vec   = gidx_q;
  assign cpu_lvl   = cur_q;
  assign stk_depth = depth_w;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vld |-> ($onehot(irq_grant) && irq_grant[irq_vec])); // R2
  AST_NO_OFF_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (glvl_q != LVL_OFF)); // R3
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !ack) |=> (vld_q && $stable(gidx_q))); // R4
  AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> (cur_q == $past(glvl_q))); // R5
  AST_CONC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vld_q) && !$past(nested_en)) |-> ($past(depth_w) == '0)); // R6
  AST_NEST_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vld_q) && $past(nested_en) && !$past(forced)) |-> (glvl_q > $past(cur_q))); // R7
  AST_HALT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vld_q) && $past(restrict_c) && !$past(forced)) |-> (|($past(cap_x) & irq_grant))); // R11
  AST_FULL_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    r_any |-> (f_any && (f_lvl >= r_lvl))); // R11
endmodule

// File: tb/sim_ic_prio_ctrl.sv
module sim_ic_prio_ctrl;
  localparam int N   = 5;
  localparam int NA  = N + 1;
  localparam int SD  = 2;
  localparam int VW  = $clog2(NA);
  localparam int DW  = $clog2(SD + 1);

  logic clk, rst_n, nested_en, tli_req, ack, rti;
  logic [1:0] sleep_st;
  logic [N-1:0] irq_req, halt_cap;
  logic [2*N-1:0] irq_lvl;
  logic irq_vld, stk_err, wake;
  logic [NA-1:0] irq_grant;
  logic [VW-1:0] irq_vec;
  logic [1:0] cpu_lvl;
  logic [DW-1:0] stk_depth;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ic_prio_ctrl #(.N_SRC(N), .STK_DEPTH(SD)) u0 (
    .clk(clk), .rst_n(rst_n), .nested_en(nested_en), .sleep_st(sleep_st),
    .irq_req(irq_req), .tli_req(tli_req), .irq_lvl(irq_lvl), .halt_cap(halt_cap),
    .ack(ack), .rti(rti), .irq_vld(irq_vld), .irq_grant(irq_grant),
    .irq_vec(irq_vec), .cpu_lvl(cpu_lvl), .stk_depth(stk_depth),
    .stk_err(stk_err), .wake(wake));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cur, m_g, m_glvl, d_idx, d_base;
  int m_stk[$];
  bit m_vld, m_err, m_lock, d_vld, d_rdy;

  function automatic int lvl_of(int a);
    if (a == 0) return 3;
    return int'(irq_lvl[2*(a-1) +: 2]);
  endfunction
  function automatic bit en_of(int a);
    if (a == 0) return tli_req;
    return irq_req[a-1] && (lvl_of(a) != 0);
  endfunction
  function automatic bit cap_of(int a);
    if (a == 0) return 1'b1;
    return halt_cap[a-1];
  endfunction
  function automatic bit elig(int a);
    if (!en_of(a)) return 1'b0;
    if (nested_en) return lvl_of(a) > m_cur;
    return m_stk.size() == 0;
  endfunction
  function automatic int pick(bit restr);
    int best = -1;
    for (int a = 0; a < NA; a++)
      if (elig(a) && (!restr || cap_of(a)) && (best < 0 || lvl_of(a) > lvl_of(best)))
        best = a;
    return best;
  endfunction
  function automatic bit m_wake();
    bit w = 0;
    for (int a = 0; a < NA; a++) begin
      if (sleep_st == 2'b01 && en_of(a)) w = 1;
      if (sleep_st == 2'b10 && en_of(a) && cap_of(a)) w = 1;
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = 0; m_g = 0; m_glvl = 0; m_vld = 0; m_err = 0; m_lock = 0;
      d_vld = 0; d_rdy = 0; d_idx = 0; d_base = 0;
      m_stk.delete();
    end else begin
      bit restr, fcd, ack_ok, rti_ok, old_vld, n_lock;
      int w, full, old_depth;
      restr = m_lock || (sleep_st == 2'b10);
      fcd = d_rdy && en_of(d_idx);
      w = fcd ? d_idx : pick(restr);
      full = pick(1'b0);
      ack_ok = ack && m_vld;
      rti_ok = rti && !ack_ok;
      old_vld = m_vld;
      old_depth = m_stk.size();
      n_lock = (sleep_st == 2'b10) || (m_lock && !ack_ok);
      if (ack_ok && m_lock && full >= 0 && full != m_g && !cap_of(full)) begin
        d_vld = 1; d_rdy = 0; d_idx = full; d_base = old_depth;
      end else if (ack_ok && d_rdy && m_g == d_idx) begin
        d_vld = 0; d_rdy = 0;
      end else if (rti_ok && d_vld && !d_rdy && old_depth == d_base + 1) begin
        d_rdy = 1;
      end else if (d_rdy && !en_of(d_idx)) begin
        d_vld = 0; d_rdy = 0;
      end
      if (ack_ok) begin
        if (m_stk.size() < SD) m_stk.push_back(m_cur);
        else m_err = 1;
        m_cur = m_glvl;
        m_vld = 0;
      end else if (rti_ok) begin
        if (m_stk.size() > 0) m_cur = m_stk.pop_back();
        else m_cur = 0;
      end
      if (!old_vld && w >= 0) begin
        m_vld = 1; m_g = w; m_glvl = lvl_of(w);
      end
      m_lock = n_lock;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 model irq_vld", int'(irq_vld), int'(m_vld));
      if (m_vld) begin
        chk("R2 model irq_vec", int'(irq_vec), m_g);
        chk("R2 model irq_grant", int'(irq_grant), 1 << m_g);
      end
      chk("R5 model cpu_lvl", int'(cpu_lvl), m_cur);
      chk("R5 model stk_depth", int'(stk_depth), m_stk.size());
      chk("R8 model stk_err", int'(stk_err), int'(m_err));
      chk("R9/R10 model wake", int'(wake), int'(m_wake()));
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask
  task automatic set_src(int k, int lv);
    irq_lvl[2*k +: 2] = 2'(lv);
    irq_req[k] = 1'b1;
  endtask
  task automatic do_ack();
    ack = 1; cyc(); ack = 0;
  endtask
  task automatic do_rti();
    rti = 1; cyc(); rti = 0;
  endtask

  initial begin
    rst_n = 0; nested_en = 0; sleep_st = 2'b00; irq_req = '0; tli_req = 0;
    irq_lvl = '0; halt_cap = '0; ack = 0; rti = 0;
    cyc(3);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 irq_vld", int'(irq_vld), 0);
    chk("R1 cpu_lvl", int'(cpu_lvl), 0);
    chk("R1 stk_depth", int'(stk_depth), 0);
    chk("R1 stk_err", int'(stk_err), 0);
    chk("R1 wake", int'(wake), 0);

    // R2 level wins; R5 ack/rti; R6 concurrent
    set_src(2, 1); set_src(4, 2);
    cyc();
    chk("R2 higher level vec", int'(irq_vec), 5);
    do_ack();
    chk("R5 level after ack", int'(cpu_lvl), 2);
    chk("R5 depth after ack", int'(stk_depth), 1);
    irq_req[4] = 0;
    set_src(0, 3);
    cyc(2);
    chk("R6 no grant in service", int'(irq_vld), 0);
    do_rti();
    chk("R5 level after rti", int'(cpu_lvl), 0);
    cyc();
    chk("R6 grant after return", int'(irq_vec), 1);
    do_ack(); irq_req[0] = 0; do_rti();
    cyc();
    chk("R2 remaining source", int'(irq_vec), 3);
    do_ack(); irq_req = '0; do_rti(); cyc();

    // R2 ties
    set_src(1, 2); set_src(3, 2);
    cyc();
    chk("R2 tie lower index", int'(irq_vec), 2);
    do_ack(); irq_req = '0; do_rti(); cyc();
    irq_req = '0; irq_lvl = '0;
    do_ack(); do_rti(); cyc();
    tli_req = 1; set_src(0, 3);
    cyc();
    chk("R2 top-level tie", int'(irq_vec), 0);
    chk("R2 one-hot", int'(irq_grant), 1);
    do_ack(); tli_req = 0; irq_req = '0; do_rti(); cyc(2);

    // R3 disabled level, R9 light sleep wake
    sleep_st = 2'b01;
    irq_lvl = '0; irq_req[2] = 1;
    cyc(2);
    chk("R3 disabled no grant", int'(irq_vld), 0);
    chk("R3 disabled no wake", int'(wake), 0);
    irq_lvl[5:4] = 2'd1;
    cyc();
    chk("R9 light sleep wake", int'(wake), 1);
    sleep_st = 2'b00;
    do_ack(); irq_req = '0; do_rti(); cyc();

    // R4 hold
    set_src(3, 1);
    cyc();
    irq_req = '0;
    cyc(2);
    chk("R4 hold valid", int'(irq_vld), 1);
    chk("R4 hold vec", int'(irq_vec), 4);
    do_ack(); do_rti(); cyc();

    // R7 nested
    nested_en = 1; irq_lvl = '0;
    set_src(3, 1);
    cyc(); do_ack(); irq_req = '0;
    set_src(1, 1);
    cyc(2);
    chk("R7 equal level blocked", int'(irq_vld), 0);
    set_src(0, 2);
    cyc();
    chk("R7 higher preempts", int'(irq_vec), 1);
    do_ack();
    chk("R5 nested depth", int'(stk_depth), 2);
    irq_req[0] = 0;
    do_rti();
    chk("R5 nested restore", int'(cpu_lvl), 1);
    do_rti(); cyc();
    chk("R7 pending after return", int'(irq_vec), 2);
    do_ack(); irq_req = '0; do_rti(); cyc();

    // R8 overflow with depth 2
    set_src(4, 1); cyc(); do_ack(); irq_req = '0;
    set_src(2, 2); cyc(); do_ack(); irq_req = '0;
    set_src(0, 3); cyc(); do_ack(); irq_req = '0;
    chk("R8 overflow flag", int'(stk_err), 1);
    chk("R8 level loaded", int'(cpu_lvl), 3);
    chk("R8 depth capped", int'(stk_depth), 2);
    do_rti();
    chk("R8 dropped push", int'(cpu_lvl), 1);
    do_rti(); cyc();
    chk("R8 sticky", int'(stk_err), 1);
    nested_en = 0; irq_lvl = '0;

    // R10 / R11 / R12 deep sleep
    halt_cap = 5'b01000;
    sleep_st = 2'b10;
    set_src(0, 3);
    cyc(2);
    chk("R10 non-capable no wake", int'(wake), 0);
    chk("R11 non-capable no grant", int'(irq_vld), 0);
    set_src(3, 1);
    cyc();
    chk("R10 capable wake", int'(wake), 1);
    chk("R11 capable first", int'(irq_vec), 4);
    sleep_st = 2'b00;
    cyc();
    do_ack();
    irq_req[3] = 0;
    tli_req = 1;
    cyc();
    do_rti(); cyc();
    chk("R12 deferred first", int'(irq_vec), 1);
    do_ack(); irq_req = '0; do_rti(); cyc();
    chk("R12 top-level after", int'(irq_vec), 0);
    do_ack(); tli_req = 0; do_rti(); cyc(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule